// File: doc/BRIEF.md
# Tone Command Interface and Dual-Tone Selector

This block sits between a host controller and a dual-tone synthesizer. It takes tone commands from the host and turns each one into two selections: a row tone index and a column tone index, each with its own enable. It also raises an oscillator-run output whenever the chip enable is active, so that the synthesizer's clock source may run.

Commands arrive on one of two paths, chosen by `mode_par`. On the serial path the host shifts in a 5-bit command, least significant bit first, on the falling edges of `ser_clk`. The serial clock and data are brought into the system clock domain by a synchronizer. On the parallel path a 4-bit code is presented on `par_code`. The tone starts once a start-up delay of `STARTUP_CYC` system clock cycles has run after chip enable goes low, and it follows the code for as long as chip enable stays low.

A four-state controller sequences the block. The states are IDLE, SERIAL, PAR_WAIT and PAR_TONE. The transitions are:
- IDLE goes to SERIAL, or to PAR_WAIT, when `cs_n` is low, with `mode_par` choosing between them.
- PAR_WAIT goes to PAR_TONE when the delay expires.
- Every active state returns to IDLE when `cs_n` goes high or `mode_par` changes.

Top module: `dtmf_cmd_if`

## Requirements
- R1: While reset is asserted and right after it, `osc_run`, `row_en` and `col_en` are 0, and both index outputs are 0.
- R2: On the first clock edge that samples `cs_n` high, `osc_run`, `row_en` and `col_en` all go to 0. The block stays in IDLE while `cs_n` is high.
- R3: A serial command is 5 bits. Each bit is taken from `ser_dat` on a falling edge of `ser_clk`, and the first bit is bit 0. The outputs change only after the fifth bit has been received.
- R4: Serial codes 1 to 9 select dual tones with row index (code-1)/3 and column index (code-1)%3. Row indices 0..3 stand for 697, 770, 852 and 941 Hz. Column indices 0..3 stand for 1209, 1336, 1477 and 1633 Hz.
- R5: Serial code 10 selects row 3 with column 1. Code 11 selects row 3 with column 0. Code 12 selects row 3 with column 2.
- R6: Serial codes 13 to 16 select rows 0 to 3, each paired with column 3.
- R7: Serial codes 17 to 20 select a row-only tone on rows 0 to 3, with `col_en`=0. Codes 21 to 24 select a column-only tone on columns 0 to 3, with `row_en`=0. Any index whose enable is 0 reads 0.
- R8: Serial codes 31, 0 and 25 to 30 give both enables 0, while `osc_run` stays 1.
- R9: A serial selection is held unchanged until the next complete 5-bit command.
- R10: In parallel mode `osc_run` rises on the first edge that samples `cs_n` low. The enables stay 0 for `STARTUP_CYC` edges and rise on the next edge.
- R11: In PAR_TONE the 4-bit code maps like serial codes 1 to 15, and code 0 selects row 3 with column 3. A change of code appears one edge later.
- R12: Raising `cs_n` clears the serial bit counter, so a partial command is discarded. If the fifth bit lands in the same cycle as the release, the release wins and that command is dropped.
- R13: A change of `mode_par` while `cs_n` is low passes through IDLE, clearing all outputs for one edge. The newly selected path then restarts; parallel mode reruns the full delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_par | input | 1 | 1 selects the parallel path, 0 the serial path |
| cs_n | input | 1 | Chip enable, active low |
| ser_clk | input | 1 | Serial shift clock, sampled on falling edges |
| ser_dat | input | 1 | Serial command data |
| par_code | input | 4 | Parallel command code |
| osc_run | output | 1 | Oscillator may run |
| row_en | output | 1 | Row tone enable |
| col_en | output | 1 | Column tone enable |
| row_idx | output | 2 | Row tone index |
| col_idx | output | 2 | Column tone index |

## Verification
Two events can land in the same system clock cycle: the synchronized falling edge that completes the fifth serial bit, and the release of chip enable. The bench provokes this by lowering `ser_clk` for the last bit and then raising `cs_n` exactly two edges later, which is the cycle in which the synchronized edge reaches the shift register. The outcome is judged by requiring that all outputs drop at that edge. After chip enable is lowered again, no tone may appear until a fresh complete command has been shifted in.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int CODE_W = 5;
    localparam int PAR_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SERIAL,
        ST_PAR_WAIT,
        ST_PAR_TONE
    } dtmf_state_e;

    typedef struct packed {
        logic       row_en;
        logic       col_en;
        logic [1:0] row;
        logic [1:0] col;
    } tone_sel_t;

    // Map a 5-bit command onto row/column selections; unused codes give silence.
    function automatic tone_sel_t decode_code(input logic [CODE_W-1:0] c);
        tone_sel_t t;
        int v;
        t = '0;
        v = int'(c);
        if (v >= 1 && v <= 9) begin
            t.row_en = 1'b1;
            t.col_en = 1'b1;
            t.row    = 2'((v - 1) / 3);
            t.col    = 2'((v - 1) % 3);
        end else if (v == 10) begin
            t.row_en = 1'b1; t.col_en = 1'b1; t.row = 2'd3; t.col = 2'd1;
        end else if (v == 11) begin
            t.row_en = 1'b1; t.col_en = 1'b1; t.row = 2'd3; t.col = 2'd0;
        end else if (v == 12) begin
            t.row_en = 1'b1; t.col_en = 1'b1; t.row = 2'd3; t.col = 2'd2;
        end else if (v >= 13 && v <= 16) begin
            t.row_en = 1'b1;
            t.col_en = 1'b1;
            t.row    = 2'(v - 13);
            t.col    = 2'd3;
        end else if (v >= 17 && v <= 20) begin
            t.row_en = 1'b1;
            t.row    = 2'(v - 17);
        end else if (v >= 21 && v <= 24) begin
            t.col_en = 1'b1;
            t.col    = 2'(v - 21);
        end
        return t;
    endfunction

    // Parallel code 0 stands for the top-row/top-column pair (serial 16).
    function automatic logic [CODE_W-1:0] par_to_code(input logic [PAR_W-1:0] p);
        return (p == '0) ? CODE_W'(16) : CODE_W'(p);
    endfunction

endpackage

// File: rtl/dtmf_edge_sync.sv
module dtmf_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdat_in,
    output logic sclk_fall,
    output logic sdat_sync
);

    logic [STAGES-1:0] clk_sr;
    logic [STAGES-1:0] dat_sr;
    logic              clk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sr   <= '1;
            dat_sr   <= '0;
            clk_prev <= 1'b1;
        end else begin
            clk_sr   <= {clk_sr[STAGES-2:0], sclk_in};
            dat_sr   <= {dat_sr[STAGES-2:0], sdat_in};
            clk_prev <= clk_sr[STAGES-1];
        end
    end

    assign sclk_fall = clk_prev & ~clk_sr[STAGES-1];
    assign sdat_sync = dat_sr[STAGES-1];

    // R3
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |=> !sclk_fall);

endmodule

// File: rtl/dtmf_ser_shift.sv
module dtmf_ser_shift #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic [CODE_W-1:0] code,
    output logic              code_stb
);

    localparam int CNT_W = $clog2(CODE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] sr;
    logic [CODE_W-1:0] sr_nxt;

    assign sr_nxt = {bit_val, sr[CODE_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            sr       <= '0;
            code     <= '0;
            code_stb <= 1'b0;
        end else if (clr) begin
            cnt      <= '0;
            sr       <= '0;
            code_stb <= 1'b0;
        end else begin
            code_stb <= 1'b0;
            if (bit_stb) begin
                sr <= sr_nxt;
                if (cnt == LAST) begin
                    cnt      <= '0;
                    code     <= sr_nxt;
                    code_stb <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R3
    bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R12
    stb_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_stb |-> ($past(bit_stb) && !$past(clr)));

endmodule

// File: rtl/dtmf_startup_timer.sv
module dtmf_startup_timer #(
    parameter int CYC = 24000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CNT_W = $clog2(CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign done = run && (cnt == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10
    delay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

endmodule

// File: rtl/dtmf_cmd_if.sv
module dtmf_cmd_if
    import dtmf_pkg::*;
#(
    parameter int STARTUP_CYC = 24000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_par,
    input  logic             cs_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic [PAR_W-1:0] par_code,
    output logic             osc_run,
    output logic             row_en,
    output logic             col_en,
    output logic [1:0]       row_idx,
    output logic [1:0]       col_idx
);

    dtmf_state_e       state, state_nxt;
    tone_sel_t         sel;
    logic              sclk_fall;
    logic              sdat_sync;
    logic [CODE_W-1:0] ser_code;
    logic              ser_code_stb;
    logic              delay_done;

    dtmf_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (ser_clk),
        .sdat_in   (ser_dat),
        .sclk_fall (sclk_fall),
        .sdat_sync (sdat_sync)
    );

    dtmf_ser_shift #(.CODE_W(CODE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_nxt != ST_SERIAL),
        .bit_stb  (sclk_fall),
        .bit_val  (sdat_sync),
        .code     (ser_code),
        .code_stb (ser_code_stb)
    );

    dtmf_startup_timer #(.CYC(STARTUP_CYC)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_PAR_WAIT),
        .done  (delay_done)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!cs_n) state_nxt = mode_par ? ST_PAR_WAIT : ST_SERIAL;
            end
            ST_SERIAL: begin
                if (cs_n || mode_par) state_nxt = ST_IDLE;
            end
            ST_PAR_WAIT: begin
                if (cs_n || !mode_par) state_nxt = ST_IDLE;
                else if (delay_done)   state_nxt = ST_PAR_TONE;
            end
            ST_PAR_TONE: begin
                if (cs_n || !mode_par) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel     <= '0;
            osc_run <= 1'b0;
        end else begin
            osc_run <= (state_nxt != ST_IDLE);
            unique case (state_nxt)
                ST_IDLE, ST_PAR_WAIT: sel <= '0;
                ST_SERIAL: begin
                    if (state != ST_SERIAL) sel <= '0;
                    else if (ser_code_stb)  sel <= decode_code(ser_code);
                end
                ST_PAR_TONE: sel <= decode_code(par_to_code(par_code));
                default: sel <= '0;
            endcase
        end
    end

    assign row_en  = sel.row_en;
    assign col_en  = sel.col_en;
    assign row_idx = sel.row;
    assign col_idx = sel.col;

    // R2
    release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!osc_run && !row_en && !col_en));

    // R8
    tone_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_en || col_en) |-> osc_run);

    // R7
    idx_zero_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!row_en -> row_idx == 2'd0) && (!col_en -> col_idx == 2'd0)));

    // R9
    serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERIAL && $past(state) == ST_SERIAL && $past(state_nxt) == ST_SERIAL
         && !$past(ser_code_stb)) |-> $stable(sel));

endmodule

// File: tb/dtmf_cmd_if_test.sv
module dtmf_cmd_if_test;

    localparam int N = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_par = 1'b0;
    logic       cs_n = 1'b1;
    logic       ser_clk = 1'b1;
    logic       ser_dat = 1'b0;
    logic [3:0] par_code = 4'd0;
    logic       osc_run, row_en, col_en;
    logic [1:0] row_idx, col_idx;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dtmf_cmd_if #(.STARTUP_CYC(N), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .cs_n(cs_n),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .par_code(par_code),
        .osc_run(osc_run), .row_en(row_en), .col_en(col_en),
        .row_idx(row_idx), .col_idx(col_idx)
    );

    // {code[4:0], row_en, col_en, row[1:0], col[1:0]}
    localparam logic [10:0] VEC [16] = '{
        {5'd1,  1'b1, 1'b1, 2'd0, 2'd0},
        {5'd5,  1'b1, 1'b1, 2'd1, 2'd1},
        {5'd9,  1'b1, 1'b1, 2'd2, 2'd2},
        {5'd10, 1'b1, 1'b1, 2'd3, 2'd1},
        {5'd11, 1'b1, 1'b1, 2'd3, 2'd0},
        {5'd12, 1'b1, 1'b1, 2'd3, 2'd2},
        {5'd13, 1'b1, 1'b1, 2'd0, 2'd3},
        {5'd16, 1'b1, 1'b1, 2'd3, 2'd3},
        {5'd17, 1'b1, 1'b0, 2'd0, 2'd0},
        {5'd20, 1'b1, 1'b0, 2'd3, 2'd0},
        {5'd21, 1'b0, 1'b1, 2'd0, 2'd0},
        {5'd24, 1'b0, 1'b1, 2'd0, 2'd3},
        {5'd31, 1'b0, 1'b0, 2'd0, 2'd0},
        {5'd6,  1'b1, 1'b1, 2'd1, 2'd2},
        {5'd0,  1'b0, 1'b0, 2'd0, 2'd0},
        {5'd25, 1'b0, 1'b0, 2'd0, 2'd0}
    };

    function automatic logic [6:0] obs();
        return {osc_run, row_en, col_en, row_idx, col_idx};
    endfunction

    task automatic chk(input string req, input logic [6:0] exp);
        checks++;
        if (obs() !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, obs(), exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bits(input logic [4:0] c, input int nb);
        for (int b = 0; b < nb; b++) send_bit(c[b]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [6:0] prev;
        repeat (3) @(negedge clk);
        chk("R1 in reset", 7'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 7'b0);

        // serial vector walk
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 serial entry silent", 7'b1000000);
        prev = 7'b1000000;
        for (int i = 0; i < 16; i++) begin
            send_bits(VEC[i][10:6], 4);
            chk("R9 R3 held during partial frame", prev);
            send_bit(VEC[i][10]);
            chk("R4 R5 R6 R7 R8 serial decode", {1'b1, VEC[i][5:0]});
            prev = {1'b1, VEC[i][5:0]};
        end

        // R2: release
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R2 release clears", 7'b0);

        // R12: partial frame discarded
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        send_bits(5'b00111, 3);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        send_bits(5'd2, 5);
        chk("R12 counter cleared by release", 7'b1110001);

        // R12: release in the cycle of the fifth bit
        send_bits(5'd3, 4);
        ser_dat = 1'b0;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R12 release wins over fifth bit", 7'b0);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b0;
        repeat (10) @(negedge clk);
        chk("R12 dropped command not applied", 7'b1000000);

        // R13: mode change while enabled
        send_bits(5'd5, 5);
        chk("R4 tone before mode change", 7'b1110101);
        mode_par = 1'b1;
        par_code = 4'd9;
        @(negedge clk);
        chk("R13 mode change passes idle", 7'b0);
        repeat (N) @(negedge clk);
        chk("R13 parallel delay rerun", 7'b1000000);
        @(negedge clk);
        chk("R13 parallel tone after delay", 7'b1111010);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R2 parallel release", 7'b0);

        // R10: start-up delay from chip enable
        par_code = 4'd5;
        cs_n = 1'b0;
        @(negedge clk);
        chk("R10 osc on first edge", 7'b1000000);
        repeat (N - 1) @(negedge clk);
        chk("R10 still silent at delay end", 7'b1000000);
        @(negedge clk);
        chk("R10 tone one edge later", 7'b1110101);

        // R11: parallel mapping follows code
        par_code = 4'd0;
        @(negedge clk);
        chk("R11 code 0 maps to top pair", 7'b1111111);
        par_code = 4'd11;
        @(negedge clk);
        chk("R11 code 11", 7'b1111100);
        par_code = 4'd14;
        @(negedge clk);
        chk("R11 code 14", 7'b1110111);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R2 final release", 7'b0);

        summary();
    end

endmodule